// File: doc/BRIEF.md
# HDLC Modem Handshake Frame Gating

This block sits between the HDLC framer of one serial channel and that channel's modem control lines. On the transmit side it drives RTS (active low) around each outgoing frame. It can hold RTS for a set number of bit times before the framer is allowed to open a frame. It keeps RTS asserted until the closing flag has left the line and a tail of bit times has passed. When CTS gating is on, it grants the start of each frame only while CTS (active low) is asserted. CTS is checked only at frame boundaries, so a drop in the middle of a frame does not abort it.

On the receive side, DSR (active low) is sampled once, on the frame-start strobe. That sample decides whether the whole frame is accepted. When forwarding is enabled, an accepted frame produces a one-cycle strobe at frame end that tells the host to take the received FCS bytes. A rejected frame forwards nothing. The block also carries the level that tells the framer whether to invert the transmitted CRC. Six option bits are loaded through a write strobe and all clear at reset.

Top module: `hdlc_mh_gate`

## Requirements
- R1: After reset all option bits are 0, rtsN=1, txGrant=0, rxAccept=0, fcsFwd=0, and crcInvert=1.
- R2: The option word written on cfgWr uses this layout: bit0 automatic RTS, bit1 CTS gating, bit2 DSR gating, bit3 mark-idle lead, bit4 CRC sent uninverted, bit5 FCS forwarding. It takes effect from the cycle after the write.
- R3: With automatic RTS set and chanEn high, rtsN is 0 in the same cycle txPending is high, and stays 0 until the transmit sequence returns to idle. With automatic RTS clear, rtsN stays 1.
- R4: With the mark-idle lead bit set, a pending frame is not granted until LEAD_BITS bitTick strobes have passed with RTS asserted. With the bit clear, the grant can come one cycle after txPending rises.
- R5: After txFrameEnd, RTS stays asserted for TAIL_BITS further bitTick strobes. It is then released if txPending is low. If txPending is high, the next frame goes to the CTS check with RTS still asserted.
- R6: With CTS gating set, txGrant is asserted only in a cycle where ctsN is 0. With gating clear, CTS is ignored.
- R7: txGrant is a single-cycle pulse, once per frame. A change of ctsN after the grant neither aborts the frame nor produces a second grant before txFrameEnd.
- R8: While chanEn is low, rtsN is 1 and txGrant is 0 in that same cycle, and the transmit sequence returns to idle.
- R9: On rxFrameStart, rxAccept becomes 1 in the next cycle if chanEn is high and either DSR gating is clear or dsrN is 0; otherwise it becomes 0. It keeps that value, whatever dsrN does, until rxFrameEnd clears it.
- R10: fcsFwd pulses for one cycle after an rxFrameEnd strobe only if the frame was accepted and FCS forwarding is set. A rejected frame never forwards.
- R11: crcInvert is 1 while option bit4 is 0, and 0 while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Load strobe for the option word |
| cfgData | input | 6 | Option word value |
| chanEn | input | 1 | Channel enable |
| txPending | input | 1 | Framer has characters waiting to send |
| bitTick | input | 1 | One strobe per line bit time |
| txFrameEnd | input | 1 | Last bit of the closing flag has gone out |
| ctsN | input | 1 | Clear to send, active low |
| dsrN | input | 1 | Data set ready, active low |
| rxFrameStart | input | 1 | Receive frame opened |
| rxFrameEnd | input | 1 | Receive frame closed |
| rtsN | output | 1 | Request to send, active low |
| txGrant | output | 1 | One-cycle permission to open a frame |
| rxAccept | output | 1 | Current received frame is accepted |
| fcsFwd | output | 1 | One-cycle strobe to pass the received FCS to the host |
| crcInvert | output | 1 | Framer should invert the transmitted CRC |

## Verification
Directed runs hold CTS deasserted while a frame waits, then release it. This tells a correct gate from one that ignores CTS or grants early. CTS is then dropped inside the frame, which separates a once-per-frame check from continuous gating. DSR is toggled between receive start and end, so sampling at the start is distinguished from sampling at the end or level tracking. Seeded random sequences mix disables in the middle of a frame, back-to-back pending frames, sparse bit ticks and option rewrites against a cycle model, which exposes off-by-one errors in the lead and tail counts.

// File: rtl/hdlc_mh_pkg.sv
package hdlc_mh_pkg;

  // option word, bit0 at the bottom
  typedef struct packed {
    logic fcsPass;   // bit5
    logic crcNoInv;  // bit4
    logic idleMark;  // bit3
    logic dsrAuto;   // bit2
    logic ctsAuto;   // bit1
    logic rtsAuto;   // bit0
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CHECK,
    ST_SEND,
    ST_TAIL
  } txState_t;

  // decisions passed from control to datapath
  typedef struct packed {
    logic txGrant;
    logic rtsDrive;
    logic rxStart;
    logic rxGo;
    logic rxEnd;
    logic fcsReq;
  } ctlStrb_t;

endpackage

// File: rtl/hdlc_mh_ctl.sv
module hdlc_mh_ctl
  import hdlc_mh_pkg::*;
#(
  parameter int LEAD_BITS = 1,
  parameter int TAIL_BITS = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     chanEn,
  input  logic     rtsAuto,
  input  logic     ctsAuto,
  input  logic     dsrAuto,
  input  logic     idleMark,
  input  logic     fcsPass,
  input  logic     txPending,
  input  logic     bitTick,
  input  logic     txFrameEnd,
  input  logic     ctsN,
  input  logic     dsrN,
  input  logic     rxFrameStart,
  input  logic     rxFrameEnd,
  input  logic     rxAccept,
  output ctlStrb_t strb
);

  localparam int MAX_BITS = (LEAD_BITS > TAIL_BITS) ? LEAD_BITS : TAIL_BITS;
  localparam int CNT_W = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_BITS - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_BITS - 1);

  txState_t st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic ctsOk, dsrOk, leadDone, tailDone;

  assign ctsOk = !ctsAuto || !ctsN;
  assign dsrOk = !dsrAuto || !dsrN;
  assign leadDone = bitTick && (cnt == LEAD_LAST);
  assign tailDone = bitTick && (cnt == TAIL_LAST);

  always_comb begin
    stNext = st;
    cntNext = cnt;
    if (!chanEn) begin
      stNext = ST_IDLE;
      cntNext = '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cntNext = '0;
          if (txPending) stNext = idleMark ? ST_LEAD : ST_CHECK;
        end
        ST_LEAD: begin
          if (leadDone) begin
            stNext = ST_CHECK;
            cntNext = '0;
          end else if (bitTick) begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_CHECK: begin
          if (ctsOk) stNext = ST_SEND;
        end
        ST_SEND: begin
          cntNext = '0;
          if (txFrameEnd) stNext = ST_TAIL;
        end
        ST_TAIL: begin
          if (tailDone) begin
            stNext = txPending ? ST_CHECK : ST_IDLE;
            cntNext = '0;
          end else if (bitTick) begin
            cntNext = cnt + 1'b1;
          end
        end
        default: begin
          stNext = ST_IDLE;
          cntNext = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      cnt <= '0;
    end else begin
      st <= stNext;
      cnt <= cntNext;
    end
  end

  always_comb begin
    strb.txGrant  = chanEn && (st == ST_CHECK) && ctsOk;
    strb.rtsDrive = chanEn && rtsAuto && ((st != ST_IDLE) || txPending);
    strb.rxStart  = rxFrameStart;
    strb.rxGo     = chanEn && dsrOk;
    strb.rxEnd    = rxFrameEnd;
    strb.fcsReq   = rxFrameEnd && rxAccept && fcsPass;
  end

endmodule

// File: rtl/hdlc_mh_dp.sv
module hdlc_mh_dp
  import hdlc_mh_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  input  ctlStrb_t         strb,
  output cfg_t             cfgQ,
  output logic             rtsN,
  output logic             txGrant,
  output logic             rxAccept,
  output logic             fcsFwd,
  output logic             crcInvert
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgWr) begin
      cfgQ <= cfg_t'(cfgData);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxAccept <= 1'b0;
      fcsFwd <= 1'b0;
    end else begin
      fcsFwd <= strb.fcsReq;
      if (strb.rxStart) rxAccept <= strb.rxGo;
      else if (strb.rxEnd) rxAccept <= 1'b0;
    end
  end

  assign rtsN = !strb.rtsDrive;
  assign txGrant = strb.txGrant;
  assign crcInvert = !cfgQ.crcNoInv;

endmodule

// File: rtl/hdlc_mh_gate.sv
module hdlc_mh_gate
  import hdlc_mh_pkg::*;
#(
  parameter int LEAD_BITS = 1,
  parameter int TAIL_BITS = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic [5:0] cfgData,
  input  logic       chanEn,
  input  logic       txPending,
  input  logic       bitTick,
  input  logic       txFrameEnd,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       rxFrameStart,
  input  logic       rxFrameEnd,
  output logic       rtsN,
  output logic       txGrant,
  output logic       rxAccept,
  output logic       fcsFwd,
  output logic       crcInvert
);

  cfg_t cfgQ;
  ctlStrb_t strb;

  hdlc_mh_ctl #(.LEAD_BITS(LEAD_BITS), .TAIL_BITS(TAIL_BITS)) u_ctl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn),
    .rtsAuto(cfgQ.rtsAuto), .ctsAuto(cfgQ.ctsAuto), .dsrAuto(cfgQ.dsrAuto),
    .idleMark(cfgQ.idleMark), .fcsPass(cfgQ.fcsPass),
    .txPending(txPending), .bitTick(bitTick), .txFrameEnd(txFrameEnd),
    .ctsN(ctsN), .dsrN(dsrN), .rxFrameStart(rxFrameStart),
    .rxFrameEnd(rxFrameEnd), .rxAccept(rxAccept), .strb(strb)
  );

  hdlc_mh_dp u_dp (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData), .strb(strb),
    .cfgQ(cfgQ), .rtsN(rtsN), .txGrant(txGrant), .rxAccept(rxAccept),
    .fcsFwd(fcsFwd), .crcInvert(crcInvert)
  );

endmodule

// File: rtl/hdlc_mh_chk.sv
module hdlc_mh_chk (
  input logic clk,
  input logic rstN,
  input logic chanEn,
  input logic ctsN,
  input logic rxFrameStart,
  input logic rxFrameEnd,
  input logic rtsAuto,
  input logic ctsAuto,
  input logic rtsN,
  input logic txGrant,
  input logic rxAccept,
  input logic fcsFwd
);

  a_r7_grant_pulse: assert property (@(posedge clk) disable iff (!rstN)
    txGrant |=> !txGrant);

  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |-> (rtsN && !txGrant));

  a_r6_cts_gate: assert property (@(posedge clk) disable iff (!rstN)
    (txGrant && ctsAuto) |-> !ctsN);

  a_r3_rts_manual: assert property (@(posedge clk) disable iff (!rstN)
    !rtsAuto |-> rtsN);

  a_r9_accept_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!rxFrameStart && !rxFrameEnd) |=> $stable(rxAccept));

  a_r10_fcs_needs_accept: assert property (@(posedge clk) disable iff (!rstN)
    fcsFwd |-> $past(rxAccept));

endmodule

bind hdlc_mh_gate hdlc_mh_chk u_chk (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .ctsN(ctsN),
  .rxFrameStart(rxFrameStart), .rxFrameEnd(rxFrameEnd),
  .rtsAuto(cfgQ.rtsAuto), .ctsAuto(cfgQ.ctsAuto),
  .rtsN(rtsN), .txGrant(txGrant), .rxAccept(rxAccept), .fcsFwd(fcsFwd)
);

// File: tb/hdlc_mh_gate_test.sv
module hdlc_mh_gate_test;

  localparam int LEADN = 2;
  localparam int TAILN = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 0, chanEn = 0, txPending = 0, bitTick = 0, txFrameEnd = 0;
  logic ctsN = 1, dsrN = 1, rxFrameStart = 0, rxFrameEnd = 0;
  logic [5:0] cfgData = '0;
  logic rtsN, txGrant, rxAccept, fcsFwd, crcInvert;

  // next-cycle stimulus
  logic nWr = 0, nEn = 0, nPend = 0, nTick = 0, nTxEnd = 0;
  logic nCts = 1, nDsr = 1, nRxS = 0, nRxE = 0;
  logic [5:0] nData = '0;

  // reference model: phase 0 idle,1 lead,2 cts check,3 sending,4 tail
  int mPh = 0, mCnt = 0;
  logic mRx = 0, mFcs = 0;
  logic [5:0] mCfg = '0;

  int total = 0, bad = 0;
  bit done = 0;
  int grants = 0;

  always #10 clk = ~clk;

  hdlc_mh_gate #(.LEAD_BITS(LEADN), .TAIL_BITS(TAILN)) uut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData), .chanEn(chanEn),
    .txPending(txPending), .bitTick(bitTick), .txFrameEnd(txFrameEnd),
    .ctsN(ctsN), .dsrN(dsrN), .rxFrameStart(rxFrameStart),
    .rxFrameEnd(rxFrameEnd), .rtsN(rtsN), .txGrant(txGrant),
    .rxAccept(rxAccept), .fcsFwd(fcsFwd), .crcInvert(crcInvert)
  );

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0b exp=%0b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  function automatic logic expCtsOk(input logic [5:0] c, input logic cts);
    return !c[1] || !cts;
  endfunction

  function automatic logic expRtsN(input logic [5:0] c, input logic en, input int ph, input logic pend);
    return !(en && c[0] && (ph != 0 || pend));
  endfunction

  task automatic step();
    logic eGrant;
    @(negedge clk);
    cfgWr = nWr; cfgData = nData; chanEn = nEn; txPending = nPend;
    bitTick = nTick; txFrameEnd = nTxEnd; ctsN = nCts; dsrN = nDsr;
    rxFrameStart = nRxS; rxFrameEnd = nRxE;
    #1;
    eGrant = chanEn && (mPh == 2) && expCtsOk(mCfg, ctsN);
    chk("R3 R4 R5 R8", "rtsN", rtsN, expRtsN(mCfg, chanEn, mPh, txPending));
    chk("R6 R7 R8", "txGrant", txGrant, eGrant);
    chk("R9", "rxAccept", rxAccept, mRx);
    chk("R10", "fcsFwd", fcsFwd, mFcs);
    chk("R2 R11", "crcInvert", crcInvert, !mCfg[4]);
    if (txGrant) grants++;
    // advance model to the next edge
    mFcs = rxFrameEnd && mRx && mCfg[5];
    if (rxFrameStart) mRx = chanEn && (!mCfg[2] || !dsrN);
    else if (rxFrameEnd) mRx = 1'b0;
    if (!chanEn) begin
      mPh = 0; mCnt = 0;
    end else begin
      case (mPh)
        0: begin mCnt = 0; if (txPending) mPh = mCfg[3] ? 1 : 2; end
        1: if (bitTick) begin
             if (mCnt == LEADN - 1) begin mPh = 2; mCnt = 0; end
             else mCnt++;
           end
        2: if (expCtsOk(mCfg, ctsN)) mPh = 3;
        3: begin mCnt = 0; if (txFrameEnd) mPh = 4; end
        default: if (bitTick) begin
             if (mCnt == TAILN - 1) begin mPh = txPending ? 2 : 0; mCnt = 0; end
             else mCnt++;
           end
      endcase
    end
    if (cfgWr) mCfg = cfgData;
  endtask

  task automatic idleIns();
    nWr = 0; nTick = 0; nTxEnd = 0; nRxS = 0; nRxE = 0;
  endtask

  task automatic cfgSet(input logic [5:0] v);
    idleIns(); nWr = 1; nData = v; step(); nWr = 0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g0;
    void'($urandom(32'd4242));
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", "rtsN", rtsN, 1'b1);
    chk("R1", "txGrant", txGrant, 1'b0);
    chk("R1", "rxAccept", rxAccept, 1'b0);
    chk("R1", "fcsFwd", fcsFwd, 1'b0);
    chk("R1", "crcInvert", crcInvert, 1'b1);
    rstN = 1'b1;
    nEn = 1;
    step();

    // R4 R6: lead + CTS held off, then released
    cfgSet(6'b001011);
    nPend = 1; nCts = 1;
    for (int i = 0; i < 8; i++) begin nTick = (i % 2 == 0); step(); end
    nTick = 0;
    repeat (4) step();
    g0 = grants;
    nCts = 0; step();
    chk("R6", "grant on CTS", (grants == g0 + 1) ? 1'b1 : 1'b0, 1'b1);
    // R7: CTS drops mid frame, no abort and no second grant
    nCts = 1; nPend = 0;
    repeat (6) step();
    chk("R7", "no regrant", (grants == g0 + 1) ? 1'b1 : 1'b0, 1'b1);
    chk("R7", "rts held", rtsN, 1'b0);
    nTxEnd = 1; step(); nTxEnd = 0;
    // R5 tail then release
    for (int i = 0; i < 8; i++) begin nTick = 1; step(); nTick = 0; step(); end
    chk("R5", "rts released", rtsN, 1'b1);

    // R5 back-to-back frame with pending during tail, CTS gating off
    cfgSet(6'b000001);
    nPend = 1; repeat (3) step();
    nTxEnd = 1; step(); nTxEnd = 0;
    for (int i = 0; i < 6; i++) begin nTick = 1; step(); end
    nTick = 0; nPend = 0; repeat (3) step();

    // R9 R10: DSR gating and FCS forwarding
    cfgSet(6'b100100);
    nDsr = 1; nRxS = 1; step(); nRxS = 0;
    nDsr = 0; repeat (3) step();
    nRxE = 1; step(); nRxE = 0; step();
    nDsr = 0; nRxS = 1; step(); nRxS = 0;
    nDsr = 1; repeat (3) step();
    chk("R9", "accept held", rxAccept, 1'b1);
    nRxE = 1; step(); nRxE = 0; step();

    // R8 disable mid frame
    cfgSet(6'b000001);
    nPend = 1; repeat (4) step();
    nEn = 0; step();
    chk("R8", "rts off", rtsN, 1'b1);
    nEn = 1; repeat (3) step();
    nPend = 0; nTxEnd = 1; step(); nTxEnd = 0;
    repeat (10) begin nTick = 1; step(); end
    nTick = 0;

    // R11 uninverted CRC
    cfgSet(6'b010000);
    step();
    chk("R11", "crc plain", crcInvert, 1'b0);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      nEn = ($urandom_range(0, 49) != 0);
      if ($urandom_range(0, 7) == 0) nPend = ~nPend;
      nTick = ($urandom_range(0, 2) == 0);
      nTxEnd = (mPh == 3) ? ($urandom_range(0, 5) == 0) : ($urandom_range(0, 39) == 0);
      nCts = ($urandom_range(0, 2) == 0);
      nDsr = ($urandom_range(0, 1) == 0);
      nRxS = ($urandom_range(0, 9) == 0);
      nRxE = ($urandom_range(0, 7) == 0);
      nWr = ($urandom_range(0, 59) == 0);
      nData = 6'($urandom_range(0, 63));
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule